// File: doc/BRIEF.md
# Wake-Up Event Output Controller

This block turns single-cycle wake indications into a conditioned wake-up output pin. There are two sources: a magic-packet match and a link-state change. A four-bit control input comes from the loaded wake-up configuration word. It enables each source on its own, picks the electrical polarity of the pin, and selects between a latched level output and a fixed-length pulse.

A two-bit sticky status register records which enabled sources have fired since the last clear. In level mode the pin stays asserted from the first enabled event until the clear input is applied. In pulse mode every enabled event starts a pulse of `PULSE_LEN` clock cycles, and a new event arriving during a pulse starts the count again. Events from a disabled source leave the pin and the status unchanged.

Top module: `wake_event_ctrl`

## Requirements
- R1: Control bit 0 selects the polarity. When it is 1 the pin is low while asserted and high while idle. When it is 0 the pin is high while asserted and low while idle.
- R2: Control bit 1 selects the output mode. A value of 1 gives pulse mode and a value of 0 gives level mode. The pin follows the mode selected at each moment.
- R3: Control bit 2 enables magic-packet events. Each enabled magic event sets status bit 0.
- R4: Control bit 3 enables link-change events. Each enabled link event sets status bit 1.
- R5: In level mode the pin asserts in the cycle after the clock edge that samples the first enabled event. It stays asserted until the clock edge that samples `clear_i`, and is idle from the following cycle.
- R6: In pulse mode each enabled event asserts the pin for exactly `PULSE_LEN` cycles (default 16), starting in the cycle after the sampling edge. An enabled event sampled during a pulse restarts the full `PULSE_LEN` count.
- R7: Status bits are sticky. They hold until `clear_i` is sampled, and `clear_i` clears both bits.
- R8: An event from a disabled source has no effect. It changes neither the pin, nor the status, nor any later pulse or level state.
- R9: When an enabled event and `clear_i` are sampled on the same edge, the event wins. Its status bit and the level latch end up set, and the status bit of the other source ends up cleared.
- R10: After reset the status is 0, the level latch is clear and no pulse is running, so the pin sits at its idle level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 4 | Control: bit0 active-low pin, bit1 pulse mode, bit2 magic enable, bit3 link enable |
| magic_evt_i | input | 1 | Single-cycle magic-packet match indication |
| link_evt_i | input | 1 | Single-cycle link-state change indication |
| clear_i | input | 1 | Clears the status and the level latch |
| wake_pin_o | output | 1 | Conditioned wake-up pin value |
| wake_status_o | output | 2 | Sticky status: bit0 magic, bit1 link |

## Verification
The clear input and an enabled event can land on the same clock edge. The clear tries to drop the status and the level latch, while the event tries to set them. The bench holds `clear_i` high in the very cycle that a magic event is presented, with the link status bit already set. It then expects the magic bit set, the link bit cleared and the level pin still asserted. A second test brings a new event during a running pulse and judges the restart by counting the asserted cycles that follow it.

// File: rtl/wake_pkg.sv
package wake_pkg;
    // Bit positions inside the control word; neighbouring logic decodes these.
    localparam int CTRL_W        = 4;
    localparam int CTRL_ACT_LOW  = 0;
    localparam int CTRL_PULSE    = 1;
    localparam int CTRL_MAGIC_EN = 2;
    localparam int CTRL_LINK_EN  = 3;

    // Event source indices, shared by the gate and the status register.
    localparam int SRC_MAGIC = 0;
    localparam int SRC_LINK  = 1;
    localparam int N_SRC     = 2;

    typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/wake_evt_gate.sv
module wake_evt_gate
    import wake_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              magic_evt_i,
    input  logic              link_evt_i,
    output src_vec_t          hit_o
);
    src_vec_t raw;
    src_vec_t en;

    always_comb begin
        raw            = '0;
        en             = '0;
        raw[SRC_MAGIC] = magic_evt_i;
        raw[SRC_LINK]  = link_evt_i;
        en[SRC_MAGIC]  = ctrl_i[CTRL_MAGIC_EN];
        en[SRC_LINK]   = ctrl_i[CTRL_LINK_EN];
    end

    // One qualifier per source.
    for (genvar g = 0; g < N_SRC; g++) begin : g_gate
        assign hit_o[g] = raw[g] & en[g];
    end
endmodule

// File: rtl/wake_status_reg.sv
module wake_status_reg
    import wake_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t hit_i,
    input  logic     clear_i,
    output src_vec_t status_o
);
    typedef struct packed {
        src_vec_t bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) st_d.bits = '0;
        st_d.bits = st_d.bits | hit_i;   // a new event outranks the clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.bits;

    for (genvar g = 0; g < N_SRC; g++) begin : g_chk
        p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.bits[g] && !clear_i) |=> st_q.bits[g])
            else $error("status bit %0d dropped without clear", g);
        p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_i[g] && clear_i) |=> st_q.bits[g])
            else $error("clear beat event on bit %0d", g);
    end
endmodule

// File: rtl/wake_pulse_timer.sv
module wake_pulse_timer #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (start_i)
            tm_d.cnt = LOAD_VAL;
        else if (tm_q.cnt != '0)
            tm_d.cnt = tm_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign active_o = (tm_q.cnt != '0);

    p_pulse_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (tm_q.cnt == LOAD_VAL))
        else $error("pulse counter not reloaded");
    p_pulse_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && tm_q.cnt != '0) |=> (tm_q.cnt == $past(tm_q.cnt) - 1'b1))
        else $error("pulse counter skipped");
    p_pulse_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && tm_q.cnt == '0) |=> !active_o)
        else $error("pulse started without event");
endmodule

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl
    import wake_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              magic_evt_i,
    input  logic              link_evt_i,
    input  logic              clear_i,
    output logic              wake_pin_o,
    output logic [N_SRC-1:0]  wake_status_o
);
    typedef struct packed {
        logic latched;
    } lv_t;

    src_vec_t hit;
    logic     any_hit;
    logic     pulse_active;
    logic     wake_active;
    lv_t      lv_d, lv_q;

    wake_evt_gate u_gate (
        .ctrl_i      (ctrl_i),
        .magic_evt_i (magic_evt_i),
        .link_evt_i  (link_evt_i),
        .hit_o       (hit)
    );

    wake_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit),
        .clear_i  (clear_i),
        .status_o (wake_status_o)
    );

    assign any_hit = |hit;

    wake_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (any_hit),
        .active_o (pulse_active)
    );

    // Level latch: set by any enabled event, dropped by clear; event wins.
    always_comb begin
        lv_d = lv_q;
        if (clear_i) lv_d.latched = 1'b0;
        if (any_hit) lv_d.latched = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lv_q <= '0;
        else        lv_q <= lv_d;
    end

    always_comb begin
        wake_active = ctrl_i[CTRL_PULSE] ? pulse_active : lv_q.latched;
        wake_pin_o  = wake_active ^ ctrl_i[CTRL_ACT_LOW];
    end

    p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lv_q.latched && !clear_i) |=> lv_q.latched)
        else $error("level latch dropped without clear");
    p_magic_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_i[CTRL_MAGIC_EN] && !wake_status_o[SRC_MAGIC]) |=> !wake_status_o[SRC_MAGIC])
        else $error("disabled magic source set status");
    p_link_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_i[CTRL_LINK_EN] && !wake_status_o[SRC_LINK]) |=> !wake_status_o[SRC_LINK])
        else $error("disabled link source set status");
    p_magic_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (magic_evt_i && ctrl_i[CTRL_MAGIC_EN]) |=> wake_status_o[SRC_MAGIC])
        else $error("enabled magic event lost");
    p_link_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (link_evt_i && ctrl_i[CTRL_LINK_EN]) |=> wake_status_o[SRC_LINK])
        else $error("enabled link event lost");
endmodule

// File: tb/wake_event_ctrl_tb.sv
module wake_event_ctrl_tb;
    localparam int PL = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ctrl_i = 4'b0000;
    logic       magic_evt_i = 1'b0;
    logic       link_evt_i = 1'b0;
    logic       clear_i = 1'b0;
    logic       wake_pin_o;
    logic [1:0] wake_status_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    wake_event_ctrl #(.PULSE_LEN(PL)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_i        (ctrl_i),
        .magic_evt_i   (magic_evt_i),
        .link_evt_i    (link_evt_i),
        .clear_i       (clear_i),
        .wake_pin_o    (wake_pin_o),
        .wake_status_o (wake_status_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Inputs change at negedges; a state update from the edge in between is seen at the next negedge.
    task automatic do_reset();
        rst_n = 1'b0;
        magic_evt_i = 0; link_evt_i = 0; clear_i = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic fire(input logic m, input logic l, input logic c);
        magic_evt_i = m; link_evt_i = l; clear_i = c;
        @(negedge clk);
        magic_evt_i = 0; link_evt_i = 0; clear_i = 0;
    endtask

    task automatic t_reset();
        ctrl_i = 4'b0000;
        do_reset();
        check("R10 status", 32'(wake_status_o), 0);
        check("R10 idle pin high-active", 32'(wake_pin_o), 0);
        ctrl_i = 4'b0001;
        #1 check("R1 idle pin active-low", 32'(wake_pin_o), 1);
        ctrl_i = 4'b0010;
        #1 check("R10 no pulse after reset", 32'(wake_pin_o), 0);
    endtask

    task automatic t_level_magic();
        ctrl_i = 4'b0100;
        do_reset();
        fire(1, 0, 0);
        check("R5 level asserted", 32'(wake_pin_o), 1);
        check("R3 magic status", 32'(wake_status_o), 2'b01);
        repeat (30) @(negedge clk);
        check("R5 level held", 32'(wake_pin_o), 1);
        check("R7 status sticky", 32'(wake_status_o), 2'b01);
        fire(0, 0, 1);
        check("R5 level released", 32'(wake_pin_o), 0);
        check("R7 status cleared", 32'(wake_status_o), 0);
    endtask

    task automatic t_link_polarity();
        ctrl_i = 4'b1001;
        do_reset();
        check("R1 idle high when active-low", 32'(wake_pin_o), 1);
        fire(0, 1, 0);
        check("R1 asserted low", 32'(wake_pin_o), 0);
        check("R4 link status", 32'(wake_status_o), 2'b10);
    endtask

    task automatic t_disabled();
        ctrl_i = 4'b0000;
        do_reset();
        fire(1, 1, 0);
        check("R8 pin unchanged", 32'(wake_pin_o), 0);
        check("R8 status unchanged", 32'(wake_status_o), 0);
        ctrl_i = 4'b0010;
        #1 check("R8 no pulse armed", 32'(wake_pin_o), 0);
        ctrl_i = 4'b0100;
        fire(0, 1, 0);
        check("R8 link off with magic on", 32'(wake_status_o), 0);
        check("R8 latch untouched", 32'(wake_pin_o), 0);
    endtask

    task automatic t_pulse();
        int n;
        ctrl_i = 4'b0110;
        do_reset();
        fire(1, 0, 0);
        n = 0;
        for (int i = 0; i < 3 * PL; i++) begin
            if (wake_pin_o) n++;
            @(negedge clk);
        end
        check("R6 pulse length", 32'(n), 32'(PL));
        check("R2 pulse ended", 32'(wake_pin_o), 0);
        ctrl_i = 4'b0100;
        #1 check("R2 level mode shows latch", 32'(wake_pin_o), 1);
    endtask

    task automatic t_pulse_restart();
        int n;
        ctrl_i = 4'b1010;
        do_reset();
        fire(0, 1, 0);
        repeat (PL / 2) @(negedge clk);
        fire(0, 1, 0);
        n = 0;
        for (int i = 0; i < 3 * PL; i++) begin
            if (wake_pin_o) n++;
            @(negedge clk);
        end
        check("R6 restart length", 32'(n), 32'(PL));
    endtask

    task automatic t_collision();
        ctrl_i = 4'b1100;
        do_reset();
        fire(0, 1, 0);
        check("R9 link set first", 32'(wake_status_o), 2'b10);
        fire(1, 0, 1);
        check("R9 event beats clear", 32'(wake_status_o), 2'b01);
        check("R9 latch kept", 32'(wake_pin_o), 1);
    endtask

    initial begin
        t_reset();
        t_level_magic();
        t_link_polarity();
        t_disabled();
        t_pulse();
        t_pulse_restart();
        t_collision();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule